// File: doc/BRIEF.md
# Program Counter Sequencer with Two-Level Return Stack

This block produces the next instruction address for a small microcontroller core. The program counter is 9 bits wide and covers a 512-word program space. On each enabled instruction cycle it either steps forward by one or takes a new value from one of four load sources. An absolute jump supplies all nine bits. A subroutine call and a computed write of the low address byte each supply eight bits, and the top bit is forced to zero, so those targets always fall in the lower half of the space. A literal return takes its address from the stack.

Beside the counter sits a two-entry return stack with no flags. A call pushes the incremented PC and pushes the oldest entry out of the stack without notice. A return pops level 1, and level 2 keeps its value, so returning too many times repeats the deepest address. A return also hands its 8-bit literal to the working register through a one-cycle load strobe. Both stack levels can be seen on debug outputs. The surrounding decoder raises at most one strobe per cycle. A fixed priority settles any overlap.

Top module: `pcstk_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `pc` = 0x1FF, both stack levels = 0x000 and `wload_stb` = 0.
- R2: On an edge with `adv_en` high and no strobe, `pc` becomes (`pc` + 1) mod 512, so 0x1FF is followed by 0x000. The stack does not change.
- R3: On an edge with `adv_en` low, `pc` and both stack levels keep their values and `wload_stb` is 0, whatever the strobes are.
- R4: An enabled `goto_stb` loads all nine bits of `goto_tgt` into `pc`. The stack does not change.
- R5: An enabled `call_stb` sets `pc` = {1'b0, `call_tgt`}. Level 2 takes the old level 1, and level 1 takes (old `pc` + 1) mod 512. A call made at 0x1FF therefore pushes 0x000.
- R6: After three or more calls in a row, the stack holds only the two most recent return addresses. No flag or other output signals the loss.
- R7: An enabled `pclw_stb` sets `pc` = {1'b0, `pclw_val`}. The stack does not change.
- R8: An enabled `ret_stb` loads `pc` from level 1, copies level 2 into level 1 and leaves level 2 unchanged. After repeated returns, both levels hold the former level-2 address.
- R9: After an enabled `ret_stb` edge, `wload_stb` is 1 for exactly one cycle and `wload_val` equals `ret_lit`. No other operation raises `wload_stb`.
- R10: If several strobes are high on one enabled edge, the order of priority is goto, then call, then return, then PCL write, then increment. Reset overrides all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Instruction-cycle enable; state changes only on edges where it is high |
| goto_stb | input | 1 | Absolute jump request |
| goto_tgt | input | 9 | Full jump target |
| call_stb | input | 1 | Subroutine call request |
| call_tgt | input | 8 | Low byte of the call target |
| pclw_stb | input | 1 | Computed write of the low PC byte |
| pclw_val | input | 8 | Value written to the low PC byte |
| ret_stb | input | 1 | Literal return request |
| ret_lit | input | 8 | Literal carried by the return |
| pc | output | 9 | Current program counter |
| wload_val | output | 8 | Literal for the working register |
| wload_stb | output | 1 | One-cycle load strobe for `wload_val` |
| stk_lvl1 | output | 9 | Debug view of stack level 1 |
| stk_lvl2 | output | 9 | Debug view of stack level 2 |

## Verification
The hardest states to reach from the ports are deep overflow and underflow. These need runs of three or more calls, or returns past an empty stack, and random stimulus seldom produces them. Directed sequences supply them, including a call placed at 0x1FF so that the pushed address wraps to 0x000. Constrained random cycles then mix all operations with gaps in `adv_en`. A few directed cycles raise several strobes together to exercise the priority order.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;
    localparam int PC_W  = 9;
    localparam int LIT_W = 8;
    localparam int STK_DEPTH = 2;
    localparam logic [PC_W-1:0] PC_RESET = {PC_W{1'b1}};

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [LIT_W-1:0] lit_t;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_GOTO,
        SEL_CALL,
        SEL_RET,
        SEL_PCLW
    } ld_sel_e;

    typedef struct packed {
        logic goto_stb;
        logic call_stb;
        logic ret_stb;
        logic pclw_stb;
        pc_t  goto_tgt;
        lit_t call_tgt;
        lit_t pclw_val;
        lit_t ret_lit;
    } ld_req_t;

    function automatic pc_t pc_inc(input pc_t p);
        return p + pc_t'(1);
    endfunction

    function automatic pc_t low_page(input lit_t v);
        return {{(PC_W-LIT_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/pcstk_sel.sv
module pcstk_sel
    import pcstk_pkg::*;
(
    input  logic    adv_en,
    input  ld_req_t req,
    output ld_sel_e sel
);
    always_comb begin
        if (!adv_en)           sel = SEL_HOLD;
        else if (req.goto_stb) sel = SEL_GOTO;
        else if (req.call_stb) sel = SEL_CALL;
        else if (req.ret_stb)  sel = SEL_RET;
        else if (req.pclw_stb) sel = SEL_PCLW;
        else                   sel = SEL_INC;
    end

    always_comb begin
        if (adv_en) begin
            AST_SEL_ACTIVE: assert (sel != SEL_HOLD); // R3
        end
    end
endmodule

// File: rtl/pcstk_stack.sv
module pcstk_stack
    import pcstk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  ld_sel_e sel,
    input  pc_t     push_addr,
    output pc_t     top,
    output pc_t     lvl [DEPTH]
);
    pc_t lvl_q   [DEPTH];
    pc_t lvl_nxt [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            lvl_nxt[i] = lvl_q[i];
            if (sel == SEL_CALL) begin
                lvl_nxt[i] = (i == 0) ? push_addr : lvl_q[(i == 0) ? 0 : i-1];
            end else if (sel == SEL_RET) begin
                lvl_nxt[i] = (i == DEPTH-1) ? lvl_q[i] : lvl_q[(i == DEPTH-1) ? i : i+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) lvl_q[i] <= '0;
            else     lvl_q[i] <= lvl_nxt[i];
        end
    end

    assign top = lvl_q[0];
    assign lvl = lvl_q;

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_CALL |=> lvl_q[1] == $past(lvl_q[0])); // R6
    AST_POP_KEEP: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_RET |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1]) && lvl_q[0] == $past(lvl_q[1])); // R8
    AST_STK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel != SEL_CALL && sel != SEL_RET) |=> $stable(lvl_q[0]) && $stable(lvl_q[1])); // R7
endmodule

// File: rtl/pcstk_pcreg.sv
module pcstk_pcreg
    import pcstk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ld_sel_e sel,
    input  ld_req_t req,
    input  pc_t     stk_top,
    output pc_t     pc_q,
    output lit_t    wval_q,
    output logic    wstb_q
);
    pc_t pc_nxt;

    always_comb begin
        unique case (sel)
            SEL_INC:  pc_nxt = pc_inc(pc_q);
            SEL_GOTO: pc_nxt = req.goto_tgt;
            SEL_CALL: pc_nxt = low_page(req.call_tgt);
            SEL_RET:  pc_nxt = stk_top;
            SEL_PCLW: pc_nxt = low_page(req.pclw_val);
            default:  pc_nxt = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= PC_RESET;
            wstb_q <= 1'b0;
            wval_q <= '0;
        end else begin
            pc_q   <= pc_nxt;
            wstb_q <= (sel == SEL_RET);
            if (sel == SEL_RET) wval_q <= req.ret_lit;
        end
    end

    AST_RESET_TOP: assert property (@(posedge clk)
        rst |=> pc_q == PC_RESET && !wstb_q); // R1
    AST_CALL_LOWPAGE: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CALL || sel == SEL_PCLW) |=> pc_q[PC_W-1] == 1'b0); // R5
    AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_HOLD |=> $stable(pc_q) && !wstb_q); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_INC |=> pc_q == pc_t'($past(pc_q) + pc_t'(1))); // R2
endmodule

// File: rtl/pcstk_seq.sv
module pcstk_seq
    import pcstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv_en,
    input  logic       goto_stb,
    input  logic [8:0] goto_tgt,
    input  logic       call_stb,
    input  logic [7:0] call_tgt,
    input  logic       pclw_stb,
    input  logic [7:0] pclw_val,
    input  logic       ret_stb,
    input  logic [7:0] ret_lit,
    output logic [8:0] pc,
    output logic [7:0] wload_val,
    output logic       wload_stb,
    output logic [8:0] stk_lvl1,
    output logic [8:0] stk_lvl2
);
    ld_req_t req;
    ld_sel_e sel;
    pc_t     top;
    pc_t     lvl [STK_DEPTH];
    pc_t     pc_q;

    assign req = '{goto_stb: goto_stb, call_stb: call_stb, ret_stb: ret_stb,
                   pclw_stb: pclw_stb, goto_tgt: goto_tgt, call_tgt: call_tgt,
                   pclw_val: pclw_val, ret_lit: ret_lit};

    pcstk_sel u_sel (
        .adv_en (adv_en),
        .req    (req),
        .sel    (sel)
    );

    pcstk_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .push_addr (pc_inc(pc_q)),
        .top       (top),
        .lvl       (lvl)
    );

    pcstk_pcreg u_pcreg (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .req     (req),
        .stk_top (top),
        .pc_q    (pc_q),
        .wval_q  (wload_val),
        .wstb_q  (wload_stb)
    );

    assign pc       = pc_q;
    assign stk_lvl1 = lvl[0];
    assign stk_lvl2 = lvl[1];

    AST_GOTO_FULL: assert property (@(posedge clk) disable iff (rst)
        adv_en && goto_stb |=> pc == $past(goto_tgt)); // R4
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
        adv_en && ret_stb && !goto_stb && !call_stb |=> pc == $past(stk_lvl1) && wload_stb && wload_val == $past(ret_lit)); // R9
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
        adv_en && call_stb && !goto_stb |=> stk_lvl1 == pc_t'($past(pc) + 9'd1)); // R10
endmodule

// File: tb/pcstk_seq_tb.sv
module pcstk_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_en = 1'b0;
    logic       goto_stb = 1'b0, call_stb = 1'b0, pclw_stb = 1'b0, ret_stb = 1'b0;
    logic [8:0] goto_tgt = '0;
    logic [7:0] call_tgt = '0, pclw_val = '0, ret_lit = '0;
    logic [8:0] pc, stk_lvl1, stk_lvl2;
    logic [7:0] wload_val;
    logic       wload_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [8:0] m_pc, m_l1, m_l2;
    logic [7:0] m_wv;
    logic       m_ws;

    always #10 clk = ~clk;

    pcstk_seq u_dut (
        .clk(clk), .rst(rst), .adv_en(adv_en),
        .goto_stb(goto_stb), .goto_tgt(goto_tgt),
        .call_stb(call_stb), .call_tgt(call_tgt),
        .pclw_stb(pclw_stb), .pclw_val(pclw_val),
        .ret_stb(ret_stb), .ret_lit(ret_lit),
        .pc(pc), .wload_val(wload_val), .wload_stb(wload_stb),
        .stk_lvl1(stk_lvl1), .stk_lvl2(stk_lvl2)
    );

    function automatic logic [8:0] inc9(input logic [8:0] p);
        return p + 9'd1;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "pc", pc, m_pc);
        cmp(tag, "lvl1", stk_lvl1, m_l1);
        cmp(tag, "lvl2", stk_lvl2, m_l2);
        cmp(tag, "wstb", {8'd0, wload_stb}, {8'd0, m_ws});
        if (m_ws) cmp(tag, "wval", {1'b0, wload_val}, {1'b0, m_wv});
    endtask

    // Drive inputs, take one edge, update model, sample mid-cycle
    task automatic cyc(input logic a, input logic g, input logic c, input logic r, input logic p,
                       input logic [8:0] gt, input logic [7:0] ct, input logic [7:0] rl,
                       input logic [7:0] pv, input string tag);
        adv_en = a; goto_stb = g; call_stb = c; ret_stb = r; pclw_stb = p;
        goto_tgt = gt; call_tgt = ct; ret_lit = rl; pclw_val = pv;
        @(posedge clk);
        m_ws = 1'b0;
        if (rst) begin
            m_pc = 9'h1FF; m_l1 = '0; m_l2 = '0;
        end else if (a) begin
            if (g) m_pc = gt;
            else if (c) begin
                m_l2 = m_l1; m_l1 = inc9(m_pc); m_pc = {1'b0, ct};
            end else if (r) begin
                m_pc = m_l1; m_l1 = m_l2; m_ws = 1'b1; m_wv = rl;
            end else if (p) m_pc = {1'b0, pv};
            else m_pc = inc9(m_pc);
        end
        #5;
        check_all(tag);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        m_wv = '0;
        seed = $urandom(32'd20240611);
        // R1 reset state, with strobes asserted to show reset wins (R10)
        rst = 1'b1;
        cyc(1, 1, 1, 0, 0, 9'h055, 8'h11, 8'h00, 8'h00, "R1");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        rst = 1'b0;
        // R2 wrap from 0x1FF to 0x000, then steps
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3 hold with strobes active but enable low
        cyc(0, 0, 1, 0, 0, 0, 8'h44, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 8'h99, 0, "R3");
        cyc(0, 1, 0, 0, 1, 9'h123, 0, 0, 8'h7E, "R3");
        // R4 goto to upper half, then to 0x1FF
        cyc(1, 1, 0, 0, 0, 9'h1A5, 0, 0, 0, "R4");
        cyc(1, 1, 0, 0, 0, 9'h1FF, 0, 0, 0, "R4");
        // R5 call at 0x1FF pushes 0x000, target's bit 8 cleared
        cyc(1, 0, 1, 0, 0, 0, 8'hF0, 0, 0, "R5");
        cyc(1, 0, 1, 0, 0, 0, 8'h20, 0, 0, "R5");
        // R6 third and fourth consecutive calls drop oldest
        cyc(1, 0, 1, 0, 0, 0, 8'h30, 0, 0, "R6");
        cyc(1, 0, 1, 0, 0, 0, 8'h40, 0, 0, "R6");
        // R7 PCL write in upper half goes to lower half, stack unchanged
        cyc(1, 1, 0, 0, 0, 9'h1C0, 0, 0, 0, "R4");
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 8'hAB, "R7");
        // R8/R9 returns past the bottom repeat level 2
        cyc(1, 0, 0, 1, 0, 0, 0, 8'h5A, 0, "R9");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 0, 1, 0, 0, 0, 8'hC3, 0, "R8");
        cyc(1, 0, 0, 1, 0, 0, 0, 8'h01, 0, "R8");
        cyc(1, 0, 0, 1, 0, 0, 0, 8'hFF, 0, "R8");
        // R10 priority among simultaneous strobes
        cyc(1, 1, 1, 1, 1, 9'h10F, 8'h22, 8'h33, 8'h44, "R10");
        cyc(1, 0, 1, 1, 1, 0, 8'h22, 8'h33, 8'h44, "R10");
        cyc(1, 0, 0, 1, 1, 0, 0, 8'h66, 8'h44, "R10");
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 8'h77, "R10");
        // Random mix, one strobe at a time
        for (int k = 0; k < 3000; k++) begin
            int unsigned op = $urandom % 10;
            logic a = ($urandom % 4) != 0;
            string tag;
            logic g = (op == 0), c = (op inside {1, 2}), r = (op inside {3, 4}), p = (op == 5);
            if (!a) tag = "R3"; else if (g) tag = "R4"; else if (c) tag = "R5";
            else if (r) tag = "R8"; else if (p) tag = "R7"; else tag = "R2";
            cyc(a, g, c, r, p, 9'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), tag);
        end
        // Mid-run reset
        rst = 1'b1;
        cyc(1, 0, 1, 0, 0, 0, 8'h12, 0, 0, "R1");
        rst = 1'b0;
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule